// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block connects a small microcontroller core to its memories. Program space and data space are two separate 64 KB regions. Each one has its own request port that carries a 16-bit address. Program fetches whose address is below 1000H can be answered by on-chip program memory instead of the external bus. The external-access pin (`ea_i`) selects which: when it is high, that low 4 KB comes from inside the chip; when it is low, every fetch goes to external memory.

External cycles use a multiplexed bus. The high address byte goes out on a dedicated port. The low address byte goes out on an 8-bit port that also carries data. An address latch enable pulse lets outside logic capture the low byte. After that come a hold phase, a turnaround phase and a strobe phase. The strobe is program-store for fetches, read for data loads and write for data stores. Every phase lasts `PH_CLKS` clocks.

A requester holds its request line high until it sees its busy flag. It then waits for its one-cycle done pulse. A data access can use a short 8-bit pointer. Such an access reaches only page 0 and leaves the high address port untouched.

Top module: `xmem_bus_if`

## Requirements
- R1: During reset and directly after it, `ale_o` is 0, `psen_n_o`, `rd_n_o` and `wr_n_o` are 1, `ad_oe_o` is 0, both busy and both done outputs are 0, and `ahi_o` is FFh.
- R2: A fetch with `ea_i`=1 and address below 1000H is served internally. It makes no ALE pulse and no strobe, and `ahi_o` keeps its value. `imem_addr_o` carries address bits 11:0, busy lasts one cycle, and `fetch_data_o` returns `imem_data_i`.
- R3: Any other fetch (`ea_i`=0, or address at or above 1000H) is external. The low address byte is on `ad_o` and the high byte on `ahi_o` while ALE is high. `psen_n_o` is low for `PH_CLKS` cycles. The byte on `ad_i` in the last strobe cycle is returned on `fetch_data_o`.
- R4: An external cycle runs four phases of `PH_CLKS` clocks each, in this order: ALE high, hold, turnaround, strobe. The address stays driven on `ad_o` through the hold phase. Busy is high for exactly 4·`PH_CLKS` cycles.
- R5: A data read (`data_we_i`=0) uses `rd_n_o`. `ad_oe_o` is 0 while `rd_n_o` is low, and the byte sampled from `ad_i` is returned on `data_rdata_o`.
- R6: A data write (`data_we_i`=1) uses `wr_n_o`. While `wr_n_o` is low, `ad_oe_o` is 1 and `ad_o` carries `data_wdata_i`.
- R7: With `data_short_i`=1, only `data_addr_i[7:0]` is issued and `ahi_o` keeps its previous value. With `data_short_i`=0, `ahi_o` carries `data_addr_i[15:8]`.
- R8: At most one of the three strobes is low in any cycle, and no strobe is low while ALE is high.
- R9: If fetch and data requests are both pending in an idle cycle, the fetch is served first. The held data request is served right after it.
- R10: Each completed access raises its done output (`fetch_done_o` or `data_done_o`) for exactly one cycle, in the cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ea_i | input | 1 | External-access level; 1 maps fetches below 1000H to internal memory |
| fetch_req_i | input | 1 | Program fetch request, held until busy |
| fetch_addr_i | input | 16 | Program address |
| fetch_busy_o | output | 1 | Fetch in progress |
| fetch_done_o | output | 1 | One-cycle fetch completion |
| fetch_data_o | output | 8 | Fetched byte, valid with done |
| imem_addr_o | output | 12 | Internal program memory address |
| imem_data_i | input | 8 | Internal program memory data |
| data_req_i | input | 1 | Data access request, held until busy |
| data_we_i | input | 1 | 1 = write, 0 = read |
| data_short_i | input | 1 | 1 = 8-bit pointer (page 0) |
| data_addr_i | input | 16 | Data address |
| data_wdata_i | input | 8 | Write byte |
| data_busy_o | output | 1 | Data access in progress |
| data_done_o | output | 1 | One-cycle data completion |
| data_rdata_o | output | 8 | Read byte, valid with done |
| ad_o | output | 8 | Low address / write data out |
| ad_oe_o | output | 1 | Output enable for the shared port |
| ad_i | input | 8 | Shared port read value |
| ahi_o | output | 8 | High address port |
| ale_o | output | 1 | Address latch enable, active high |
| psen_n_o | output | 1 | Program store strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |

## Verification
Fetches are run on both sides of 1000H with `ea_i` at each level. This separates the internal route from the external one, and it catches a wrong boundary or a wrong pin polarity. Data reads and writes are run with long and short pointers, and each result is compared with a model of the high address port. This shows whether a short access wrongly overwrites the high byte, and whether a strobe is mixed up or the bus is driven during a read. Fetch and data requests are also raised in the same cycle to check the serving order, and random traffic mixes all kinds back to back.

// File: rtl/xmem_bus_if.sv
module xmem_bus_if #(
  parameter int PH_CLKS = 2,
  parameter int INT_TOP = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ea_i,
  input  logic        fetch_req_i,
  input  logic [15:0] fetch_addr_i,
  output logic        fetch_busy_o,
  output logic        fetch_done_o,
  output logic [7:0]  fetch_data_o,
  output logic [11:0] imem_addr_o,
  input  logic [7:0]  imem_data_i,
  input  logic        data_req_i,
  input  logic        data_we_i,
  input  logic        data_short_i,
  input  logic [15:0] data_addr_i,
  input  logic [7:0]  data_wdata_i,
  output logic        data_busy_o,
  output logic        data_done_o,
  output logic [7:0]  data_rdata_o,
  output logic [7:0]  ad_o,
  output logic        ad_oe_o,
  input  logic [7:0]  ad_i,
  output logic [7:0]  ahi_o,
  output logic        ale_o,
  output logic        psen_n_o,
  output logic        rd_n_o,
  output logic        wr_n_o
);
  localparam int CW = (PH_CLKS > 1) ? $clog2(PH_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PH_CLKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_INT, S_ADDR, S_HOLD, S_TURN, S_STRB} st_t;
  typedef enum logic [1:0] {K_FETCH, K_RD, K_WR} kind_t;

  st_t           st;
  kind_t         kind;
  logic [CW-1:0] cnt;
  logic [7:0]    lo_q, wd_q, hi_q, rd_q;
  logic [11:0]   ia_q;
  logic          fdone_q, ddone_q;
  logic          last;

  assign last = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind    <= K_FETCH;
      cnt     <= '0;
      lo_q    <= '0;
      wd_q    <= '0;
      hi_q    <= 8'hFF;
      rd_q    <= '0;
      ia_q    <= '0;
      fdone_q <= 1'b0;
      ddone_q <= 1'b0;
    end else begin
      fdone_q <= 1'b0;
      ddone_q <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (fetch_req_i) begin
            kind <= K_FETCH;
            lo_q <= fetch_addr_i[7:0];
            ia_q <= fetch_addr_i[11:0];
            if (ea_i && ({1'b0, fetch_addr_i} < 17'(INT_TOP))) begin
              st <= S_INT;
            end else begin
              hi_q <= fetch_addr_i[15:8];
              st   <= S_ADDR;
            end
          end else if (data_req_i) begin
            kind <= data_we_i ? K_WR : K_RD;
            lo_q <= data_addr_i[7:0];
            wd_q <= data_wdata_i;
            if (!data_short_i) hi_q <= data_addr_i[15:8];
            st <= S_ADDR;
          end
        end
        S_INT: begin
          rd_q    <= imem_data_i;
          fdone_q <= 1'b1;
          st      <= S_IDLE;
        end
        S_ADDR, S_HOLD, S_TURN: begin
          if (last) begin
            cnt <= '0;
            st  <= (st == S_ADDR) ? S_HOLD : (st == S_HOLD) ? S_TURN : S_STRB;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STRB: begin
          if (last) begin
            if (kind != K_WR) rd_q <= ad_i;
            if (kind == K_FETCH) fdone_q <= 1'b1;
            else ddone_q <= 1'b1;
            st <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire phase_late = (st == S_TURN) || (st == S_STRB);

  assign fetch_busy_o = (st != S_IDLE) && (kind == K_FETCH);
  assign data_busy_o  = (st != S_IDLE) && (kind != K_FETCH);
  assign fetch_done_o = fdone_q;
  assign data_done_o  = ddone_q;
  assign fetch_data_o = rd_q;
  assign data_rdata_o = rd_q;
  assign imem_addr_o  = ia_q;
  assign ahi_o        = hi_q;
  assign ale_o        = (st == S_ADDR);
  assign psen_n_o     = !((st == S_STRB) && (kind == K_FETCH));
  assign rd_n_o       = !((st == S_STRB) && (kind == K_RD));
  assign wr_n_o       = !((st == S_STRB) && (kind == K_WR));
  assign ad_oe_o      = (st == S_ADDR) || (st == S_HOLD) || (phase_late && kind == K_WR);
  assign ad_o         = phase_late ? wd_q : lo_q;
endmodule

module xmem_bus_if_chk (
  input logic clk,
  input logic rst_n,
  input logic ale_o,
  input logic psen_n_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic ad_oe_o,
  input logic fetch_done_o,
  input logic data_done_o
);
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n_o, !rd_n_o, !wr_n_o}) <= 1);
  a_r8_no_strobe_in_ale: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (psen_n_o && rd_n_o && wr_n_o));
  a_r5_float_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe_o);
  a_r6_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> ad_oe_o);
  a_r4_addr_held_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_o) |-> ad_oe_o);
  a_r10_fetch_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done_o |=> !fetch_done_o);
  a_r10_data_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    data_done_o |=> !data_done_o);
endmodule

bind xmem_bus_if xmem_bus_if_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ale_o(ale_o), .psen_n_o(psen_n_o),
  .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .ad_oe_o(ad_oe_o),
  .fetch_done_o(fetch_done_o), .data_done_o(data_done_o)
);

// File: tb/xmem_bus_if_tb_top.sv
module xmem_bus_if_tb_top;
  localparam int P = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ea = 1'b0, freq = 1'b0, dreq = 1'b0, dwe = 1'b0, dshort = 1'b0;
  logic [15:0] faddr = '0, daddr = '0;
  logic [7:0]  dwd = '0, ad_in = '0, imem_data;
  logic        fbusy, fdone, dbusy, ddone, ad_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0]  fdata, drdata, ad_out, ahi;
  logic [11:0] imem_addr;

  int n_chk = 0, n_bad = 0;
  logic [7:0] hi_m = 8'hFF;

  always #10 clk = ~clk;

  function automatic logic [7:0] imem_model(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  assign imem_data = imem_model(imem_addr);

  xmem_bus_if #(.PH_CLKS(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .ea_i(ea),
    .fetch_req_i(freq), .fetch_addr_i(faddr), .fetch_busy_o(fbusy),
    .fetch_done_o(fdone), .fetch_data_o(fdata),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .data_req_i(dreq), .data_we_i(dwe), .data_short_i(dshort),
    .data_addr_i(daddr), .data_wdata_i(dwd), .data_busy_o(dbusy),
    .data_done_o(ddone), .data_rdata_o(drdata),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .ahi_o(ahi),
    .ale_o(ale), .psen_n_o(psen_n), .rd_n_o(rd_n), .wr_n_o(wr_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // k: 0 fetch, 1 data read, 2 data write
  task automatic run(input int k, input logic [15:0] a, input logic e,
                     input logic sh, input logic [7:0] wv, input logic [7:0] xv);
    int ale_n = 0, ps_n = 0, rdn = 0, wrn = 0, busy_n = 0, bad_oe = 0, bad_wd = 0, bad_ov = 0, cyc = 0;
    logic [7:0] lo_s = '0, hi_s = '0, dv = '0, exp_hi, exp_d;
    logic got = 1'b0, intern, hi_upd;
    intern = (k == 0) && e && (a < 16'h1000);
    hi_upd = ((k == 0) && !intern) || ((k != 0) && !sh);
    exp_hi = hi_upd ? a[15:8] : hi_m;
    exp_d  = intern ? imem_model(a[11:0]) : xv;
    @(negedge clk);
    ea = e; ad_in = xv;
    if (k == 0) begin freq = 1'b1; faddr = a; end
    else begin dreq = 1'b1; daddr = a; dwe = (k == 2); dshort = sh; dwd = wv; end
    while (!got && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (fbusy || dbusy) begin busy_n++; freq = 1'b0; dreq = 1'b0; end
      if (ale) begin ale_n++; lo_s = ad_out; hi_s = ahi; end
      if (!psen_n) ps_n++;
      if (!rd_n) begin rdn++; if (ad_oe) bad_oe++; end
      if (!wr_n) begin wrn++; if (!ad_oe || ad_out != wv) bad_wd++; end
      if ((int'(!psen_n) + int'(!rd_n) + int'(!wr_n) > 1) ||
          (ale && !(psen_n && rd_n && wr_n))) bad_ov++;
      if (fdone || ddone) begin got = 1'b1; dv = (k == 0) ? fdata : drdata; end
    end
    freq = 1'b0; dreq = 1'b0;
    chk(got, "R10 completion seen", int'(got), 1);
    chk(busy_n == (intern ? 1 : 4 * P), intern ? "R2 busy length" : "R4 busy length", busy_n, intern ? 1 : 4 * P);
    chk(ale_n == (intern ? 0 : P), intern ? "R2 no ALE" : "R4 ALE length", ale_n, intern ? 0 : P);
    chk(ps_n == ((k == 0 && !intern) ? P : 0), "R3 psen cycles", ps_n, (k == 0 && !intern) ? P : 0);
    chk(rdn == ((k == 1) ? P : 0), "R5 rd cycles", rdn, (k == 1) ? P : 0);
    chk(wrn == ((k == 2) ? P : 0), "R6 wr cycles", wrn, (k == 2) ? P : 0);
    chk(bad_oe == 0, "R5 bus floated in read", bad_oe, 0);
    chk(bad_wd == 0, "R6 write data driven", bad_wd, 0);
    chk(bad_ov == 0, "R8 strobe exclusivity", bad_ov, 0);
    if (!intern) begin
      chk(lo_s == a[7:0], "R3 low address", lo_s, a[7:0]);
      chk(hi_s == exp_hi, sh ? "R7 high port kept" : "R7 high port", hi_s, exp_hi);
    end else begin
      chk(ahi == hi_m, "R2 high port untouched", ahi, hi_m);
    end
    if (k != 2) chk(dv == exp_d, intern ? "R2 internal data" : "R3 read data", dv, exp_d);
    if (hi_upd) hi_m = a[15:8];
    @(negedge clk);
    chk(!fdone && !ddone, "R10 done single cycle", int'(fdone | ddone), 0);
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!ale && psen_n && rd_n && wr_n && !ad_oe, "R1 bus idle in reset", {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fbusy && !dbusy && !fdone && !ddone, "R1 handshake idle", {fbusy, dbusy, fdone, ddone}, 0);
    chk(ahi == 8'hFF, "R1 high port reset", ahi, 8'hFF);

    run(0, 16'h0FFF, 1'b1, 1'b0, 8'h00, 8'h11);
    run(0, 16'h1000, 1'b1, 1'b0, 8'h00, 8'h22);
    run(0, 16'h0123, 1'b0, 1'b0, 8'h00, 8'h33);
    run(0, 16'h0000, 1'b1, 1'b0, 8'h00, 8'h44);
    run(1, 16'hABCD, 1'b1, 1'b0, 8'h00, 8'h55);
    run(2, 16'h3456, 1'b0, 1'b1, 8'hC3, 8'h00);
    run(1, 16'h9977, 1'b0, 1'b1, 8'h00, 8'h66);
    run(2, 16'hFFFF, 1'b1, 1'b0, 8'h3C, 8'h00);

    begin : prio_r9
      int first = 0, order = 0, cyc = 0;
      @(negedge clk);
      ea = 1'b0; freq = 1'b1; faddr = 16'h2345; dreq = 1'b1; daddr = 16'h7710;
      dwe = 1'b0; dshort = 1'b0; ad_in = 8'h99;
      while (order < 2 && cyc < 200) begin
        @(negedge clk);
        cyc++;
        if (fbusy) begin freq = 1'b0; if (first == 0) first = 1; end
        if (dbusy) begin dreq = 1'b0; if (first == 0) first = 2; end
        if (fdone && order == 0) order = 1;
        if (ddone && order == 1) order = 2;
      end
      freq = 1'b0; dreq = 1'b0;
      chk(first == 1, "R9 fetch served first", first, 1);
      chk(order == 2, "R9 data served after fetch", order, 2);
      hi_m = 8'h77;
      @(negedge clk);
    end

    for (int i = 0; i < 60; i++) begin
      int k;
      k = int'($urandom_range(0, 2));
      run(k, 16'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule